// File: doc/BRIEF.md
# Tag Match Comparator

This unit adds compare cycles to a synchronous SRAM. A compare cycle is issued like a read, but the memory core keeps its data drivers off. This leaves the bus free for the expected tag, which is captured into the unit's data input register. The word that the array returns is then checked against that registered tag, bit for bit, and the result is a single match flag.

The flag follows the same latency choice as the read data path. In flow-through operation the result appears in the cycle that carries the read word. In pipeline operation it appears one cycle later, from a dedicated result register. A separate enable acts on the match driver without waiting for a clock edge. The result register keeps its value through cycles that carry no compare.

Top module: `tag_match_unit`

## Requirements
- R1: At each rising clock edge with `de` high, the tag register captures `din_word`. With `de` low, the tag register keeps its value.
- R2: The match result is 1 only when every bit of `rd_word` equals the tag register. This covers all `W` bits, including the two top parity bits [W-1:W-2].
- R3: With `lat_pipe` low and `cmp_valid` high, `match_out` shows the result of the current cycle's compare, before the next clock edge.
- R4: With `lat_pipe` high, a compare made in one cycle shows on `match_out` in the following cycle. In the compare cycle itself, the output still shows the earlier result.
- R5: When `cmp_valid` is low at a clock edge, the stored result keeps its value. `match_out` then shows that stored value in both modes.
- R6: `match_drv_en` follows `match_oe` asynchronously. While `match_oe` is low, `match_out` is 0.
- R7: While `rst_n` is low, the stored result is 0, so `match_out` reads 0 with the driver enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lat_pipe | input | 1 | 1 = pipeline result latency, 0 = flow-through |
| de | input | 1 | Data enable for the tag (data input) register |
| din_word | input | W | Expected tag from the data bus |
| cmp_valid | input | 1 | Current cycle is a compare and `rd_word` is valid |
| rd_word | input | W | Word read from the array |
| match_oe | input | 1 | Asynchronous match output enable |
| match_out | output | 1 | Match result, 0 while disabled |
| match_drv_en | output | 1 | Drive enable for the match pin |

## Verification
The bench makes mismatches that differ only in a parity bit. A comparator that is too narrow would report a hit for these. It loads a new tag in the same cycle as a compare, which shows whether the old tag is used. A design that compared against the incoming bus word would fail here. It switches to pipeline mode and checks that the compare cycle still shows the previous result. A bypass wired the wrong way round would show the new result one cycle early. It also toggles the match enable between clock edges, so a clocked enable would show up as a stale driver state.

// File: rtl/tag_match_unit.sv
module tag_match_unit #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lat_pipe,
  input  logic         de,
  input  logic [W-1:0] din_word,
  input  logic         cmp_valid,
  input  logic [W-1:0] rd_word,
  input  logic         match_oe,
  output logic         match_out,
  output logic         match_drv_en
);

  logic [W-1:0] tag_q;
  logic         held_q;
  logic         hit_now;
  logic         flag;

  assign hit_now = (rd_word == tag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else if (de) tag_q <= din_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b0;
    else if (cmp_valid) held_q <= hit_now;
  end

  assign flag         = (!lat_pipe && cmp_valid) ? hit_now : held_q;
  assign match_drv_en = match_oe;
  assign match_out    = match_oe & flag;

endmodule

module tag_match_chk #(
  parameter int W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lat_pipe,
  input logic         de,
  input logic [W-1:0] din_word,
  input logic         cmp_valid,
  input logic [W-1:0] rd_word,
  input logic         match_oe,
  input logic         match_out,
  input logic [W-1:0] tag_q,
  input logic         held_q
);

  assert_tag_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    de |=> tag_q == $past(din_word));

  assert_tag_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !de |=> $stable(tag_q));

  assert_flow_same_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && !lat_pipe && match_oe) |-> match_out == (rd_word == tag_q));

  assert_pipe_next_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid && lat_pipe) |=> (!lat_pipe || !match_oe || match_out == $past(rd_word == tag_q)));

  assert_hold_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_valid |=> $stable(held_q));

  assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !match_oe |-> !match_out);

endmodule

bind tag_match_unit tag_match_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .lat_pipe(lat_pipe), .de(de), .din_word(din_word),
  .cmp_valid(cmp_valid), .rd_word(rd_word), .match_oe(match_oe),
  .match_out(match_out), .tag_q(tag_q), .held_q(held_q)
);

// File: tb/tag_match_unit_tb.sv
module tag_match_unit_tb_top;
  localparam int W = 18;
  localparam time CLK_P = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lat_pipe = 1'b0;
  logic         de = 1'b0;
  logic [W-1:0] din_word = '0;
  logic         cmp_valid = 1'b0;
  logic [W-1:0] rd_word = '0;
  logic         match_oe = 1'b1;
  logic         match_out;
  logic         match_drv_en;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct { int due; logic val; logic en; string req; } exp_t;
  exp_t sb[$];

  logic [W-1:0] tag_m = '0;
  logic         held_m = 1'b0;

  tag_match_unit #(.W(W)) dut_i (.*);

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic step(input logic pipe, input logic oe, input logic d, input logic [W-1:0] dw,
                      input logic c, input logic [W-1:0] rw, input string req);
    logic hit, v;
    @(negedge clk);
    lat_pipe = pipe; match_oe = oe; de = d; din_word = dw; cmp_valid = c; rd_word = rw;
    hit = (rw == tag_m);
    v = (!pipe && c) ? hit : held_m;
    sb.push_back('{due: cyc, val: oe & v, en: oe, req: req});
    if (c) held_m = hit;
    if (d) tag_m = dw;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        check(match_out, e.val, e.req, "match_out");
        check(match_drv_en, e.en, "R6", "match_drv_en");
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 5000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  localparam logic [W-1:0] TAG_A = 18'h2A5C3;
  localparam logic [W-1:0] TAG_B = 18'h15A3C;

  initial begin : driver
    repeat (2) @(negedge clk);
    check(match_out, 1'b0, "R7", "reset value");
    @(negedge clk);
    rst_n = 1'b1;
    // R1 load, then R3/R2 flow-through compares
    step(0, 1, 1, TAG_A, 0, '0, "R1");
    step(0, 1, 0, '0, 1, TAG_A, "R3");
    step(0, 1, 0, '0, 1, TAG_A ^ 18'h20000, "R2");
    step(0, 1, 0, '0, 1, TAG_A ^ 18'h10000, "R2");
    step(0, 1, 0, '0, 1, TAG_A ^ 18'h00001, "R2");
    step(0, 1, 0, '0, 1, TAG_A, "R3");
    // R5 hold with no compare
    step(0, 1, 0, '0, 0, TAG_B, "R5");
    step(0, 1, 0, '0, 0, '0, "R5");
    // R1 compare uses old tag while new one loads
    step(0, 1, 1, TAG_B, 1, TAG_A, "R1");
    step(0, 1, 0, 18'h3FFFF, 1, TAG_B, "R1");
    step(0, 1, 0, '0, 1, 18'h3FFFF, "R1");
    // R4 pipeline latency
    step(1, 1, 0, '0, 1, TAG_B, "R4");
    step(1, 1, 0, '0, 1, TAG_B ^ 18'h20000, "R4");
    step(1, 1, 0, '0, 0, '0, "R4");
    step(1, 1, 0, '0, 0, TAG_B, "R5");
    step(1, 1, 0, '0, 1, TAG_B, "R4");
    step(1, 1, 0, '0, 0, '0, "R4");
    // R6 disabled driver
    step(1, 0, 0, '0, 0, '0, "R6");
    step(0, 0, 0, '0, 1, TAG_B, "R6");
    step(0, 1, 0, '0, 0, '0, "R5");
    repeat (2) @(negedge clk);
    // R6 asynchronous toggling between edges
    cmp_valid = 1'b0;
    #1 match_oe = 1'b0;
    #1 check(match_drv_en, 1'b0, "R6", "async off");
    check(match_out, 1'b0, "R6", "async off out");
    #1 match_oe = 1'b1;
    #1 check(match_drv_en, 1'b1, "R6", "async on");
    check(match_out, held_m, "R6", "async on out");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule